// File: doc/BRIEF.md
# Mode-Selectable Registered Transceiver with Loopback

This block is a bidirectional data path of `DATA_W` bits with three buses. The A side has a separate input bus and output bus. The B side is a single shared bus driven in open-drain style: a bit is pulled low for a 0 and released for a 1. An external pull-up supplies the high level. The block has two storage elements. The forward element moves A input data toward the B bus. The reverse element moves data toward the A output. Each element is set at run time by its own two-bit mode code to act as a pass-through, an edge-captured register or a level-sensitive latch. Each direction has its own strobe input, which is the capture clock in register mode and the open enable in latch mode.

A loop select steers the reverse element's input. It takes either the B bus or the forward element's output, so the forward path can be read back on the A output for diagnostics without using the B bus. Output enables switch the A output to high impedance and release the B bus. Storage keeps working while the outputs are off. An edge-rate select input is registered and returned as a status bit. It has no effect on the data.

All logic runs on one clock with a synchronous active-high reset. The strobes are sampled on that clock. A strobe "rise" is an edge at which the strobe is sampled high after it was sampled low at the previous edge.

Top module: `modal_loop_xcvr`

## Requirements
- R1: Each element decodes its own mode code independently: 2'b00 is pass-through, 2'b01 is edge-captured register, and 2'b10 and 2'b11 are both latch.
- R2: In register mode, the element loads its input at a clock edge that sees a strobe rise. At every other edge, including while the strobe stays high, it keeps its value. Its output shows the stored value.
- R3: In latch mode, the output equals the element input at once while the strobe is high. Storage loads the input at every clock edge where the strobe is high. While the strobe is low, the output holds the value loaded at the last such edge.
- R4: In pass-through mode, the element output equals its input with no clock delay, and the stored value is left untouched for later register or latch use.
- R5: With loop select low, the reverse element's input is the resolved B bus. With it high, the input is the forward element's output. This holds in every mode.
- R6: The A output is high impedance while its enable is low and shows the reverse element's output while the enable is high.
- R7: The block pulls B bus bits low only when `b_en` is 1 and `b_en_n` is 0. With any other combination, every bit is released.
- R8: Switching either output enable never alters stored data, and both elements keep capturing while their outputs are off.
- R9: Polarity is true in both directions. A forward output bit of 0 pulls the B bit low and a 1 releases it. A low B bit reaches the A output as 0.
- R10: `slow_edge_stat` equals `slow_edge_sel` as sampled at the previous clock edge, and it has no effect on any data bus.
- R11: A clock edge with `rst` high clears both storage elements, the strobe history and the edge-rate status to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for storage, strobe sampling and status |
| rst | input | 1 | Synchronous reset, active high |
| a_din | input | DATA_W | A-side input data, forward element input |
| a_dout | output | DATA_W | A-side output, tri-stated by `a_dout_en` |
| b_io | inout | DATA_W | Shared open-drain B bus, pulled up externally |
| fwd_mode | input | 2 | Forward element mode code |
| rev_mode | input | 2 | Reverse element mode code |
| fwd_stb | input | 1 | Forward capture strobe or latch enable |
| rev_stb | input | 1 | Reverse capture strobe or latch enable |
| loop_sel | input | 1 | 1: reverse input from forward output; 0: from B bus |
| a_dout_en | input | 1 | A output enable, active high |
| b_en | input | 1 | B drive enable, active high |
| b_en_n | input | 1 | B drive enable, active low |
| slow_edge_sel | input | 1 | Edge-rate select (1 slow, 0 fast) |
| slow_edge_stat | output | 1 | Registered copy of the edge-rate select |

## Verification
The properties assume that the strobes, modes and loop select change only away from the clock edge. They also assume that the B bus seen by the reverse element is fully resolved at each edge, with no other driver fighting the block's release. The bench changes every input two time units after a rising edge and checks one time unit later or after the next edge. Its own B driver is open-drain like the block's, so the bus always resolves as a wired AND. The A output has a weak pull-down in the bench, so a high-impedance output reads as zero. That is why each disabled-output case uses data with ones in it.

// File: rtl/modal_xcvr_pkg.sv
package modal_xcvr_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    XM_PASS  = 2'b00,
    XM_FLOP  = 2'b01,
    XM_LATCH = 2'b10
  } xfer_kind_e;

  // Upper bit set means latch regardless of the lower bit.
  function automatic xfer_kind_e decode_kind(input logic [MODE_W-1:0] code);
    if (code[1])      return XM_LATCH;
    else if (code[0]) return XM_FLOP;
    else              return XM_PASS;
  endfunction
endpackage

// File: rtl/xfer_element.sv
module xfer_element
  import modal_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              strobe,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] held
);
  xfer_kind_e kind;
  logic       strobe_q;
  logic       strobe_rise;

  assign kind        = decode_kind(mode);
  assign strobe_rise = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else begin
      case (kind)
        XM_FLOP:  if (strobe_rise) held <= d;
        XM_LATCH: if (strobe)      held <= d;
        default:  held <= held;
      endcase
    end
  end

  always_comb begin
    case (kind)
      XM_FLOP:  y = held;
      XM_LATCH: y = strobe ? d : held;
      default:  y = d;
    endcase
  end
endmodule

// File: rtl/b_port_drive.sv
module b_port_drive #(
  parameter int DATA_W = 8
) (
  input  logic              en,
  input  logic              en_n,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] pull_low
);
  logic active;

  assign active = en & ~en_n;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign pull_low[i] = active & ~data[i];
  end
endmodule

// File: rtl/modal_loop_xcvr.sv
module modal_loop_xcvr
  import modal_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  inout  wire  [DATA_W-1:0] b_io,
  input  logic [MODE_W-1:0] fwd_mode,
  input  logic [MODE_W-1:0] rev_mode,
  input  logic              fwd_stb,
  input  logic              rev_stb,
  input  logic              loop_sel,
  input  logic              a_dout_en,
  input  logic              b_en,
  input  logic              b_en_n,
  input  logic              slow_edge_sel,
  output logic              slow_edge_stat
);
  logic [DATA_W-1:0] fwd_y;
  logic [DATA_W-1:0] fwd_store;
  logic [DATA_W-1:0] rev_y;
  logic [DATA_W-1:0] rev_store;
  logic [DATA_W-1:0] rev_d;
  logic [DATA_W-1:0] b_sense;
  logic [DATA_W-1:0] b_pull_low;

  xfer_element #(.DATA_W(DATA_W)) u_fwd (
    .clk    (clk),
    .rst    (rst),
    .mode   (fwd_mode),
    .strobe (fwd_stb),
    .d      (a_din),
    .y      (fwd_y),
    .held   (fwd_store)
  );

  assign b_sense = b_io;
  assign rev_d   = loop_sel ? fwd_y : b_sense;

  xfer_element #(.DATA_W(DATA_W)) u_rev (
    .clk    (clk),
    .rst    (rst),
    .mode   (rev_mode),
    .strobe (rev_stb),
    .d      (rev_d),
    .y      (rev_y),
    .held   (rev_store)
  );

  b_port_drive #(.DATA_W(DATA_W)) u_bdrv (
    .en       (b_en),
    .en_n     (b_en_n),
    .data     (fwd_y),
    .pull_low (b_pull_low)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_bpin
    assign b_io[i] = b_pull_low[i] ? 1'b0 : 1'bz;
  end

  assign a_dout = a_dout_en ? rev_y : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (rst) slow_edge_stat <= 1'b0;
    else     slow_edge_stat <= slow_edge_sel;
  end
endmodule

// File: rtl/modal_loop_xcvr_chk.sv
module modal_loop_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        fwd_mode,
  input logic [1:0]        rev_mode,
  input logic              fwd_stb,
  input logic              loop_sel,
  input logic              b_en,
  input logic              b_en_n,
  input logic [DATA_W-1:0] a_din,
  input logic [DATA_W-1:0] fwd_y,
  input logic [DATA_W-1:0] rev_y,
  input logic [DATA_W-1:0] fwd_store,
  input logic [DATA_W-1:0] rev_store,
  input logic [DATA_W-1:0] b_pull_low
);
  // R2
  flop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_mode == 2'b01 && !fwd_stb) |=> $stable(fwd_store));

  // R2
  flop_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_mode == 2'b01 && fwd_stb && !$past(fwd_stb)) |=> (fwd_store == $past(a_din)));

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_mode[1] && fwd_stb) |=> (fwd_store == $past(a_din)));

  // R4
  pass_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_mode == 2'b00) |=> $stable(fwd_store));

  // R5
  loop_route_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_sel && rev_mode == 2'b00) |-> (rev_y == fwd_y));

  // R7
  b_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(b_en && !b_en_n) |-> (b_pull_low == '0));

  // R9
  b_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    (b_en && !b_en_n) |-> (b_pull_low == ~fwd_y));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (fwd_store == '0 && rev_store == '0));
endmodule

bind modal_loop_xcvr modal_loop_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fwd_mode   (fwd_mode),
  .rev_mode   (rev_mode),
  .fwd_stb    (fwd_stb),
  .loop_sel   (loop_sel),
  .b_en       (b_en),
  .b_en_n     (b_en_n),
  .a_din      (a_din),
  .fwd_y      (fwd_y),
  .rev_y      (rev_y),
  .fwd_store  (fwd_store),
  .rev_store  (rev_store),
  .b_pull_low (b_pull_low)
);

// File: tb/modal_loop_xcvr_tb.sv
module modal_loop_xcvr_tb;
  localparam int W = 8;
  localparam int NVEC = 9;

  // {loop_sel, a_dout_en, b_en, b_en_n, a_din, b_ext, exp_bus, exp_aout}
  localparam logic [35:0] VEC [NVEC] = '{
    36'h6_A5_FF_A5_A5,
    36'h6_3C_F0_30_30,
    36'h7_00_5A_5A_5A,
    36'h4_00_FF_FF_FF,
    36'h5_12_C3_C3_C3,
    36'hF_96_00_00_96,
    36'hE_E7_FF_E7_E7,
    36'h2_81_FF_81_00,
    36'hB_7F_FF_FF_00
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_din = '0;
  logic [1:0]   fwd_mode = 2'b00;
  logic [1:0]   rev_mode = 2'b00;
  logic         fwd_stb = 1'b0;
  logic         rev_stb = 1'b0;
  logic         loop_sel = 1'b0;
  logic         a_dout_en = 1'b0;
  logic         b_en = 1'b0;
  logic         b_en_n = 1'b1;
  logic         slow_edge_sel = 1'b0;
  logic         slow_edge_stat;
  logic [W-1:0] b_ext = '1;
  wire  [W-1:0] a_dout;
  wire  [W-1:0] b_bus;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < W; i++) begin : g_bench_bus
    pullup   u_pu (b_bus[i]);
    pulldown u_pd (a_dout[i]);
    assign b_bus[i] = b_ext[i] ? 1'bz : 1'b0;
  end

  modal_loop_xcvr #(.DATA_W(W)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .a_din          (a_din),
    .a_dout         (a_dout),
    .b_io           (b_bus),
    .fwd_mode       (fwd_mode),
    .rev_mode       (rev_mode),
    .fwd_stb        (fwd_stb),
    .rev_stb        (rev_stb),
    .loop_sel       (loop_sel),
    .a_dout_en      (a_dout_en),
    .b_en           (b_en),
    .b_en_n         (b_en_n),
    .slow_edge_sel  (slow_edge_sel),
    .slow_edge_stat (slow_edge_stat)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset with registers selected and a non-zero status input
    fwd_mode = 2'b01; rev_mode = 2'b01; a_dout_en = 1'b1;
    b_en = 1'b1; b_en_n = 1'b0; a_din = 8'hFF; slow_edge_sel = 1'b1;
    tick(); tick();
    chk("R11 bus after reset", b_bus, 8'h00);
    chk("R11 a_dout after reset", a_dout, 8'h00);
    chk("R11 status after reset", {7'd0, slow_edge_stat}, 8'h00);
    rst = 1'b0;
    tick();
    chk("R10 status follows select", {7'd0, slow_edge_stat}, 8'h01);

    // Vector table, pass-through both ways (R1 R5 R6 R7 R9)
    fwd_mode = 2'b00; rev_mode = 2'b00;
    for (int k = 0; k < NVEC; k++) begin
      {loop_sel, a_dout_en, b_en, b_en_n} = VEC[k][35:32];
      a_din = VEC[k][31:24];
      b_ext = VEC[k][23:16];
      #1;
      chk("R7 R9 vector bus", b_bus, VEC[k][15:8]);
      chk("R5 R6 vector a_dout", a_dout, VEC[k][7:0]);
      tick();
    end

    // R2: register mode, both directions
    fwd_mode = 2'b01; rev_mode = 2'b01; loop_sel = 1'b0;
    a_dout_en = 1'b1; b_en = 1'b1; b_en_n = 1'b0; b_ext = 8'hFF;
    a_din = 8'h5A;
    tick();
    chk("R2 hold without strobe", b_bus, 8'h00);
    fwd_stb = 1'b1;
    tick();
    chk("R2 capture on strobe rise", b_bus, 8'h5A);
    chk("R1 reverse independent", a_dout, 8'h00);
    a_din = 8'hC3;
    tick();
    chk("R2 strobe held high no capture", b_bus, 8'h5A);
    rev_stb = 1'b1;
    tick();
    chk("R2 R9 reverse capture from bus", a_dout, 8'h5A);
    fwd_stb = 1'b0; rev_stb = 1'b0;
    tick();
    fwd_stb = 1'b1;
    tick();
    chk("R2 second rise", b_bus, 8'hC3);

    // R8: capture with outputs off
    b_en = 1'b0; a_dout_en = 1'b0;
    #1;
    chk("R7 bus released", b_bus, 8'hFF);
    chk("R6 a_dout high impedance", a_dout, 8'h00);
    fwd_stb = 1'b0; a_din = 8'h66;
    tick();
    fwd_stb = 1'b1;
    tick();
    b_en = 1'b1; a_dout_en = 1'b1;
    #1;
    chk("R8 captured while disabled", b_bus, 8'h66);
    chk("R8 reverse kept", a_dout, 8'h5A);

    // R3: forward latch read back through loop
    fwd_mode = 2'b10; rev_mode = 2'b00; loop_sel = 1'b1; b_en = 1'b0;
    a_din = 8'h24;
    #1;
    chk("R3 R5 transparent", a_dout, 8'h24);
    tick();
    a_din = 8'h99;
    #1;
    chk("R3 follows while open", a_dout, 8'h99);
    tick();
    fwd_stb = 1'b0; a_din = 8'h11;
    #1;
    chk("R3 holds when closed", a_dout, 8'h99);
    tick();
    chk("R3 holds over edge", a_dout, 8'h99);
    fwd_mode = 2'b11;
    #1;
    chk("R1 code 11 latch closed", a_dout, 8'h99);
    fwd_stb = 1'b1;
    #1;
    chk("R1 code 11 latch open", a_dout, 8'h11);
    tick();

    // R4: pass-through leaves storage alone
    fwd_mode = 2'b00; a_din = 8'h42; fwd_stb = 1'b0;
    #1;
    chk("R4 pass-through", a_dout, 8'h42);
    tick();
    fwd_stb = 1'b1;
    tick();
    fwd_mode = 2'b01;
    #1;
    chk("R4 storage untouched", a_dout, 8'h11);
    tick();
    chk("R4 no rise after switch", a_dout, 8'h11);

    // R3: reverse latch from the bus
    loop_sel = 1'b0; rev_mode = 2'b10; rev_stb = 1'b1; b_ext = 8'h3E;
    #1;
    chk("R3 reverse transparent", a_dout, 8'h3E);
    tick();
    rev_stb = 1'b0; b_ext = 8'h00;
    #1;
    chk("R3 reverse hold", a_dout, 8'h3E);
    tick();
    chk("R3 reverse hold over edge", a_dout, 8'h3E);

    // R10: status only
    slow_edge_sel = 1'b0;
    #1;
    chk("R10 status before edge", {7'd0, slow_edge_stat}, 8'h01);
    chk("R10 no data effect", a_dout, 8'h3E);
    tick();
    chk("R10 status after edge", {7'd0, slow_edge_stat}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule